// File: doc/BRIEF.md
# Iterative RC6 Block Cipher Core

This core encrypts or decrypts one 128-bit block with the RC6 round structure. It processes one round per clock cycle. The block is held as four words, A, B, C and D, each of `W` bits. Each round mixes the words through data-dependent rotations. The rotation amounts come from the quadratic term x*(2x+1). Additive whitening is applied before the first round and after the last one. A single direction input selects whether the block is encrypted or decrypted.

The core does not store the key. It puts out a round index on `key_idx`, and an external key table answers combinationally with the two subkeys for that index. The data side works like a one-entry FIFO. The core takes a block through a write strobe while `busy` is low. It then holds the result, flagged by `out_valid`, until the consumer acknowledges it. Key expansion, the key table itself and chaining modes belong to the surrounding design.

The controller is a six-state machine:

| State | What happens | Transitions |
|-------|--------------|-------------|
| IDLE | Waiting for a block | Goes to WAIT on a write |
| WAIT | Block captured, key table not yet valid | Goes to PRE once `key_ok` is high |
| PRE | Input whitening | Always goes to ROUND |
| ROUND | One round per cycle | Goes to POST after round `R` |
| POST | Output whitening | Always goes to HOLD |
| HOLD | Result presented | Goes back to IDLE on `out_ack` |

Top module: `rc6_iter_core`

## Requirements
- R1: After reset, `busy` is 0, `out_valid` is 0, `key_free` is 1 and `blk_out` is all zeros.
- R2: With `dir_dec`=0, the result is RC6 encryption of the block, packed as `blk_in` = {A,B,C,D} with A in the top `W` bits.
  - Whitening: B+=S[0] and D+=S[1].
  - Each round i=1..R computes t=rotl(B*(2B+1),log2 W) and u=rotl(D*(2D+1),log2 W).
  - It then sets A=rotl(A^t,u)+S[2i] and C=rotl(C^u,t)+S[2i+1], and finally rotates (A,B,C,D)<=(B,C,D,A).
  - Closing step: A+=S[2R+2] and C+=S[2R+3].
  - All arithmetic is modulo 2^W, and every rotation uses only the low log2(W) bits of its amount.
- R3: With `dir_dec`=1, the core applies the inverse steps in reverse order. Decrypting an encrypted block with the same key table returns the original block.
- R4: Key index k stands for the subkey pair S[2k] on `key_even` and S[2k+1] on `key_odd`.
  - Encryption presents indices 0, 1, ..., R, R+1 in its whitening, round and whitening cycles.
  - Decryption presents R+1, R, ..., 1, 0.
- R5: A write is taken only when `busy` is 0. `busy` rises at the capturing edge and stays high until the result is acknowledged. A write made while `busy` is 1 changes neither the result in progress nor the state after it.
- R6: While `key_ok` is low after a capture, the core stays in WAIT: `key_idx` stays constant and no result appears.
- R7: With `key_ok` high, `out_valid` rises at the (R+4)-th rising edge, counting the capturing edge as the first.
- R8: While `out_ack` is low, `out_valid` stays high and `blk_out` does not change. The edge that samples `out_ack` high clears `out_valid`.
- R9: `key_free` is 0 exactly during the R+2 cycles that read the key table. It is 1 in IDLE, WAIT and HOLD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_dec | input | 1 | 1 = decrypt, 0 = encrypt; sampled with the write |
| blk_in | input | 4*W | Input block {A,B,C,D} |
| blk_wr | input | 1 | Write strobe for `blk_in` |
| busy | output | 1 | Core holds a block (full) |
| blk_out | output | 4*W | Result block {A,B,C,D} |
| out_valid | output | 1 | Result available |
| out_ack | input | 1 | Consumer has taken the result |
| key_idx | output | IDXW | Round index presented to the key table |
| key_even | input | W | Subkey S[2*key_idx] |
| key_odd | input | W | Subkey S[2*key_idx+1] |
| key_ok | input | 1 | Key table content is valid |
| key_free | output | 1 | Key table is not being read |

## Verification
The bench builds the core with W=8 and R=4. With these values a whole block is 32 bits, rotation amounts take three bits, and every run takes only a few cycles. The bench encrypts hundreds of blocks under two key tables and checks each result against its own arithmetic model. It then decrypts each ciphertext back to its plaintext. With blocks this small, the sweep covers every rotation amount and every byte value of each word. It also steps through the whole index sequence in both directions, including the waits for `key_ok`, the writes made while `busy` is high, and a result held for several cycles before it is acknowledged.

// File: rtl/rc6i_pkg.sv
package rc6i_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_ROUND,
        ST_POST,
        ST_HOLD
    } rc_state_e;
endpackage

// File: rtl/rc6i_ctrl.sv
module rc6i_ctrl
    import rc6i_pkg::*;
#(
    parameter int R    = 20,
    parameter int IDXW = $clog2(R + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_wr,
    input  logic            dir_dec,
    input  logic            key_ok,
    input  logic            out_ack,
    output rc_state_e       state,
    output logic            dec_q,
    output logic [IDXW-1:0] idx_q,
    output logic            load,
    output logic            adv,
    output logic            busy,
    output logic            out_valid,
    output logic            key_free
);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(R + 1);
    localparam logic [IDXW-1:0] IDX_R    = IDXW'(R);
    localparam logic [IDXW-1:0] IDX_ONE  = IDXW'(1);

    rc_state_e nxt;
    logic      last_round;

    assign last_round = dec_q ? (idx_q == IDX_ONE) : (idx_q == IDX_R);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (blk_wr) nxt = ST_WAIT;
            ST_WAIT:  if (key_ok) nxt = ST_PRE;
            ST_PRE:   nxt = ST_ROUND;
            ST_ROUND: if (last_round) nxt = ST_POST;
            ST_POST:  nxt = ST_HOLD;
            ST_HOLD:  if (out_ack) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dec_q <= 1'b0;
            idx_q <= '0;
        end else begin
            state <= nxt;
            if (load) begin
                dec_q <= dir_dec;
                idx_q <= dir_dec ? IDX_LAST : '0;
            end else if (state == ST_PRE || state == ST_ROUND) begin
                idx_q <= dec_q ? idx_q - 1'b1 : idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        load      = 1'b0;
        adv       = 1'b0;
        busy      = 1'b1;
        out_valid = 1'b0;
        key_free  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = blk_wr;
            end
            ST_WAIT: ;
            ST_PRE, ST_ROUND, ST_POST: begin
                adv      = 1'b1;
                key_free = 1'b0;
            end
            ST_HOLD:  out_valid = 1'b1;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rc6i_step.sv
module rc6i_step
    import rc6i_pkg::*;
#(
    parameter int W   = 32,
    parameter int LGW = $clog2(W)
) (
    input  rc_state_e      state,
    input  logic           dec,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W-1:0]   c_i,
    input  logic [W-1:0]   d_i,
    input  logic [W-1:0]   k_even,
    input  logic [W-1:0]   k_odd,
    output logic [W-1:0]   a_o,
    output logic [W-1:0]   b_o,
    output logic [W-1:0]   c_o,
    output logic [W-1:0]   d_o
);
    localparam logic [LGW-1:0] QSH = LGW'(LGW);

    function automatic logic [W-1:0] rol(input logic [W-1:0] x, input logic [LGW-1:0] s);
        logic [2*W-1:0] dbl;
        dbl = {x, x} << s;
        return dbl[2*W-1:W];
    endfunction

    function automatic logic [W-1:0] ror(input logic [W-1:0] x, input logic [LGW-1:0] s);
        logic [2*W-1:0] dbl;
        dbl = {x, x} >> s;
        return dbl[W-1:0];
    endfunction

    function automatic logic [W-1:0] quad(input logic [W-1:0] x);
        logic [W-1:0] prod;
        prod = x * {x[W-2:0], 1'b1};
        return rol(prod, QSH);
    endfunction

    // Encryption uses (B,D) for t,u; decryption after its pre-rotation uses (A,C).
    logic [W-1:0] t_src, u_src, t_v, u_v;

    assign t_src = dec ? a_i : b_i;
    assign u_src = dec ? c_i : d_i;
    assign t_v   = quad(t_src);
    assign u_v   = quad(u_src);

    always_comb begin
        a_o = a_i;
        b_o = b_i;
        c_o = c_i;
        d_o = d_i;
        unique case (state)
            ST_PRE: begin
                if (dec) begin
                    a_o = a_i - k_even;
                    c_o = c_i - k_odd;
                end else begin
                    b_o = b_i + k_even;
                    d_o = d_i + k_odd;
                end
            end
            ST_ROUND: begin
                if (dec) begin
                    a_o = ror(d_i - k_even, u_v[LGW-1:0]) ^ t_v;
                    b_o = a_i;
                    c_o = ror(b_i - k_odd, t_v[LGW-1:0]) ^ u_v;
                    d_o = c_i;
                end else begin
                    a_o = b_i;
                    b_o = rol(c_i ^ u_v, t_v[LGW-1:0]) + k_odd;
                    c_o = d_i;
                    d_o = rol(a_i ^ t_v, u_v[LGW-1:0]) + k_even;
                end
            end
            ST_POST: begin
                if (dec) begin
                    b_o = b_i - k_even;
                    d_o = d_i - k_odd;
                end else begin
                    a_o = a_i + k_even;
                    c_o = c_i + k_odd;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rc6_iter_core.sv
module rc6_iter_core
    import rc6i_pkg::*;
#(
    parameter int W = 32,
    parameter int R = 20,
    localparam int IDXW = $clog2(R + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_dec,
    input  logic [4*W-1:0]  blk_in,
    input  logic            blk_wr,
    output logic            busy,
    output logic [4*W-1:0]  blk_out,
    output logic            out_valid,
    input  logic            out_ack,
    output logic [IDXW-1:0] key_idx,
    input  logic [W-1:0]    key_even,
    input  logic [W-1:0]    key_odd,
    input  logic            key_ok,
    output logic            key_free
);
    rc_state_e    state;
    logic         dec_q, load, adv;
    logic [W-1:0] wa, wb, wc, wd;
    logic [W-1:0] na, nb, nc, nd;

    rc6i_ctrl #(.R(R), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .dir_dec(dir_dec),
        .key_ok(key_ok), .out_ack(out_ack), .state(state), .dec_q(dec_q),
        .idx_q(key_idx), .load(load), .adv(adv), .busy(busy),
        .out_valid(out_valid), .key_free(key_free)
    );

    rc6i_step #(.W(W)) u_step (
        .state(state), .dec(dec_q),
        .a_i(wa), .b_i(wb), .c_i(wc), .d_i(wd),
        .k_even(key_even), .k_odd(key_odd),
        .a_o(na), .b_o(nb), .c_o(nc), .d_o(nd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {wa, wb, wc, wd} <= '0;
        end else if (load) begin
            {wa, wb, wc, wd} <= blk_in;
        end else if (adv) begin
            {wa, wb, wc, wd} <= {na, nb, nc, nd};
        end
    end

    assign blk_out = {wa, wb, wc, wd};
endmodule

// File: rtl/rc6_iter_chk.sv
module rc6_iter_chk #(
    parameter int W = 32,
    parameter int R = 20,
    localparam int IDXW = $clog2(R + 2)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            blk_wr,
    input logic            busy,
    input logic [4*W-1:0]  blk_out,
    input logic            out_valid,
    input logic            out_ack,
    input logic [IDXW-1:0] key_idx,
    input logic            key_ok,
    input logic            key_free
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && key_free));

    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blk_wr) |=> (busy && !out_valid));

    a_r6_wait_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_free && !out_valid && !key_ok) |=> ($stable(key_idx) && !out_valid));

    a_r4_index_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_free && $past(!key_free)) |-> (key_idx != $past(key_idx)));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(blk_out)));

    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack) |=> !out_valid);

    a_r9_free_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> key_free);
endmodule

bind rc6_iter_core rc6_iter_chk #(.W(W), .R(R)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .busy(busy), .blk_out(blk_out),
    .out_valid(out_valid), .out_ack(out_ack), .key_idx(key_idx),
    .key_ok(key_ok), .key_free(key_free)
);

// File: tb/tb_rc6_iter_core.sv
`timescale 1ns/1ps
module tb_rc6_iter_core;
    localparam int W  = 8;
    localparam int R  = 4;
    localparam int NK = 2 * R + 4;
    localparam int IDXW = $clog2(R + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dir_dec = 1'b0;
    logic [4*W-1:0]  blk_in = '0;
    logic            blk_wr = 1'b0;
    logic            busy;
    logic [4*W-1:0]  blk_out;
    logic            out_valid;
    logic            out_ack = 1'b0;
    logic [IDXW-1:0] key_idx;
    logic [W-1:0]    key_even, key_odd;
    logic            key_ok = 1'b1;
    logic            key_free;

    logic [7:0] ktab [NK];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rc6_iter_core #(.W(W), .R(R)) dut (
        .clk(clk), .rst_n(rst_n), .dir_dec(dir_dec), .blk_in(blk_in),
        .blk_wr(blk_wr), .busy(busy), .blk_out(blk_out), .out_valid(out_valid),
        .out_ack(out_ack), .key_idx(key_idx), .key_even(key_even),
        .key_odd(key_odd), .key_ok(key_ok), .key_free(key_free)
    );

    always_comb begin
        key_even = 8'h00;
        key_odd  = 8'h00;
        if (int'(key_idx) <= R + 1) begin
            key_even = ktab[2 * int'(key_idx)];
            key_odd  = ktab[2 * int'(key_idx) + 1];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rl(input logic [7:0] x, input int n);
        logic [7:0] v = x;
        for (int k = 0; k < (n % 8); k++) v = {v[6:0], v[7]};
        return v;
    endfunction

    function automatic logic [7:0] qf(input logic [7:0] x);
        int m;
        m = int'(x) * (2 * int'(x) + 1);
        return rl(m[7:0], 3);
    endfunction

    function automatic logic [31:0] ref_enc(input logic [31:0] p);
        logic [7:0] a, b, c, d, t, u, tmp;
        {a, b, c, d} = p;
        b = b + ktab[0];
        d = d + ktab[1];
        for (int i = 1; i <= R; i++) begin
            t = qf(b);
            u = qf(d);
            a = rl(a ^ t, int'(u)) + ktab[2*i];
            c = rl(c ^ u, int'(t)) + ktab[2*i+1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + ktab[2*R+2];
        c = c + ktab[2*R+3];
        return {a, b, c, d};
    endfunction

    task automatic load_keys(input int seed);
        for (int k = 0; k < NK; k++) ktab[k] = 8'((k * 73 + seed * 29 + 11) ^ (k << 3));
    endtask

    task automatic run(input logic dec, input logic [31:0] din,
                       output logic [31:0] dout, output int lat);
        @(negedge clk);
        dir_dec = dec;
        blk_in  = din;
        blk_wr  = 1'b1;
        @(negedge clk);
        blk_wr = 1'b0;
        lat = 1;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        dout = blk_out;
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] p, ct, pt, hold_v;
        int lat;
        load_keys(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 key_free", 32'(key_free), 1);
        chk("R1 blk_out", blk_out, 0);

        // R4 / R9: index order and key_free in encryption
        @(negedge clk);
        dir_dec = 1'b0; blk_in = 32'h01234567; blk_wr = 1'b1;
        @(negedge clk);
        blk_wr = 1'b0;
        chk("R5 busy after write", 32'(busy), 1);
        chk("R9 key_free in wait", 32'(key_free), 1);
        for (int j = 0; j <= R + 1; j++) begin
            @(negedge clk);
            chk("R4 enc key_idx", 32'(key_idx), 32'(j));
            chk("R9 key_free reading", 32'(key_free), 0);
        end
        @(negedge clk);
        chk("R7 out_valid", 32'(out_valid), 1);
        chk("R9 key_free in hold", 32'(key_free), 1);
        chk("R2 enc result", blk_out, ref_enc(32'h01234567));
        ct = blk_out;
        // R8 held for several cycles without ack
        hold_v = blk_out;
        repeat (3) @(negedge clk);
        chk("R8 still valid", 32'(out_valid), 1);
        chk("R8 stable", blk_out, hold_v);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk("R8 drop after ack", 32'(out_valid), 0);
        chk("R5 idle after ack", 32'(busy), 0);

        // R4 decryption index order
        @(negedge clk);
        dir_dec = 1'b1; blk_in = ct; blk_wr = 1'b1;
        @(negedge clk);
        blk_wr = 1'b0;
        for (int j = 0; j <= R + 1; j++) begin
            @(negedge clk);
            chk("R4 dec key_idx", 32'(key_idx), 32'(R + 1 - j));
        end
        @(negedge clk);
        chk("R3 dec result", blk_out, 32'h01234567);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;

        // R6 wait for key_ok
        key_ok = 1'b0;
        @(negedge clk);
        dir_dec = 1'b0; blk_in = 32'hDEADBEEF; blk_wr = 1'b1;
        @(negedge clk);
        blk_wr = 1'b0;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R6 no result while keys invalid", 32'(out_valid), 0);
            chk("R6 key_idx held", 32'(key_idx), 0);
        end
        key_ok = 1'b1;
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R6 result after key_ok", blk_out, ref_enc(32'hDEADBEEF));
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;

        // R5 writes while busy are ignored
        @(negedge clk);
        dir_dec = 1'b0; blk_in = 32'hA5A55A5A; blk_wr = 1'b1;
        @(negedge clk);
        blk_in = 32'h11111111; dir_dec = 1'b1;
        repeat (R + 6) @(negedge clk);
        blk_wr = 1'b0;
        chk("R5 ignored write keeps result", blk_out, ref_enc(32'hA5A55A5A));
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk("R5 no new block taken", 32'(busy), 0);

        // R2/R3/R7 sweeps over two key tables
        for (int ks = 1; ks <= 2; ks++) begin
            load_keys(ks * 5);
            for (int n = 0; n < 256; n++) begin
                p = {8'(n), 8'(n ^ 8'h5A), 8'(~n), 8'(n * 3 + ks)};
                if (ks == 2) p = p ^ 32'(n * 32'h9E3779B1);
                run(1'b0, p, ct, lat);
                chk("R2 enc sweep", ct, ref_enc(p));
                chk("R7 latency", 32'(lat), 32'(R + 4));
                run(1'b1, ct, pt, lat);
                chk("R3 round trip", pt, p);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule